// File: doc/BRIEF.md
# Banked GPIO Port with Edge Interrupts

This block is a 24-line general-purpose I/O port that a host reaches through a simple synchronous register bus. The bus has an address, write data with a write strobe, and a read strobe with registered read data. The lines are grouped into three 8-bit banks. Each line can be an input or an output. Its output level is changed only by writing ones to a set register or to a clear register. The level of every pin can be read back through a monitor register.

Each line also has its own rising-edge and falling-edge detect enables. A detected edge latches both a sticky edge flag and a sticky status flag. The host clears either flag by writing a one back to it. A per-line interrupt enable masks the status flags. One registered, active-high interrupt output goes high when any enabled status flag is set.

Register groups use a stride of four addresses: address = group*4 + slot. Slot 0 holds the most significant bank (lines 16..23), slot 1 holds lines 8..15 and slot 2 holds lines 0..7. A host that reads upward from the base of a group therefore gets the top bank first.

Top module: `gpx_port`

## Requirements
- R1: After reset every register is zero: all lines are inputs (pin_oe = 0, pin_out = 0), the irq output is 0, and every mapped address reads 0 while all pins are low.
- R2: Line n lives in bank n/8, bit n%8. Group codes are: 0 pin monitor, 1 direction, 2 set, 3 clear, 4 rising enable, 5 falling enable, 6 interrupt enable, 7 status, 8 edge flags. The address is group*4 + (2 - bank).
- R3: Writing the set group drives high each line whose data bit is 1. Zero bits leave the line unchanged. Reading either the set or the clear group returns the output latch.
- R4: Writing the clear group drives low each line whose data bit is 1. Zero bits leave the line unchanged.
- R5: Direction bit 1 makes a line an output. pin_oe equals the direction bits, and pin_out carries the latch only where the direction is 1 (it is 0 elsewhere).
- R6: The pin-monitor group returns the level of every line, inputs and outputs alike, after a two-flop synchronizer. A level held for three cycles is visible on a read.
- R7: A line latches its edge flag and status flag when its synchronized level rises and its rising enable is set, or falls and its falling enable is set. Both enables together catch either edge. A level held steady never sets a flag.
- R8: Status and edge flags stay set until a 1 is written to their bit. A written 0 has no effect, and an edge that is detected in the same cycle as a clear leaves the flag set.
- R9: irq goes to 1 one cycle after any status bit is set together with its interrupt-enable bit, and is 0 one cycle after no such pair remains.
- R10: Read data appears the cycle after rd_en. Slot 3 of any group and any group above 8 read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 6 | Register address (group in bits 5:2, slot in bits 1:0) |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Read data, valid the cycle after rd_en |
| pin_in | input | 24 | Pin levels seen from the pads |
| pin_out | output | 24 | Output levels, gated by direction |
| pin_oe | output | 24 | Output enables (direction bits) |
| irq | output | 1 | Registered interrupt request |

## Verification
A corrupted edge or status flag shows up on irq one cycle after the flag settles, and on the status or edge read four cycles after the pin moves. An enable bit steered to the wrong line or bank shows as a flag in the wrong bit position of that readback. A clear mask that is reversed or applied too broadly shows in the next read of the flag group. A bad output latch shows at once on pin_out, and after the synchronizer delay on the loop-backed monitor read. The sweep visits every line under all four rising/falling enable combinations, so a fault in any single line shows up within that line's pass.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  parameter int BANKS      = 3;
  parameter int BANK_W     = 8;
  parameter int SLOT_BITS  = 2;
  parameter int GROUP_BITS = 4;
  localparam int ADDR_W    = GROUP_BITS + SLOT_BITS;
  localparam int LINES     = BANKS * BANK_W;
  localparam int BIDX_W    = (BANKS > 1) ? $clog2(BANKS) : 1;

  typedef enum logic [GROUP_BITS-1:0] {
    GRP_PIN  = 4'd0,
    GRP_DIR  = 4'd1,
    GRP_SET  = 4'd2,
    GRP_CLR  = 4'd3,
    GRP_RISE = 4'd4,
    GRP_FALL = 4'd5,
    GRP_IEN  = 4'd6,
    GRP_STAT = 4'd7,
    GRP_EDGE = 4'd8
  } grp_e;

  typedef struct packed {
    logic [BANKS-1:0]  dirWr;
    logic [BANKS-1:0]  setWr;
    logic [BANKS-1:0]  clrWr;
    logic [BANKS-1:0]  riseWr;
    logic [BANKS-1:0]  fallWr;
    logic [BANKS-1:0]  ienWr;
    logic [BANKS-1:0]  statClr;
    logic [BANKS-1:0]  edgeClr;
    logic [BANK_W-1:0] data;
    logic              rdEn;
    logic              rdHit;
    grp_e              rdGrp;
    logic [BIDX_W-1:0] rdBank;
  } strobe_t;
endpackage

// File: rtl/gpx_ctrl.sv
module gpx_ctrl
  import gpx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [BANK_W-1:0] wrData,
  output strobe_t           st
);
  localparam int LAST_GRP = int'(GRP_EDGE);

  logic [GROUP_BITS-1:0] grp;
  logic [SLOT_BITS-1:0]  slot;
  logic                  hit;
  logic [BANKS-1:0]      bankSel;

  assign grp  = addr[ADDR_W-1 -: GROUP_BITS];
  assign slot = addr[SLOT_BITS-1:0];
  assign hit  = (int'(slot) < BANKS) && (int'(grp) <= LAST_GRP);

  // slot 0 addresses the top bank; bank index counts down with the slot
  for (genvar b = 0; b < BANKS; b++) begin : g_sel
    assign bankSel[b] = hit && (int'(slot) == BANKS - 1 - b);
  end

  function automatic logic [BANKS-1:0] wrSel(input grp_e g);
    return (wrEn && grp == g) ? bankSel : '0;
  endfunction

  always_comb begin
    st.dirWr   = wrSel(GRP_DIR);
    st.setWr   = wrSel(GRP_SET);
    st.clrWr   = wrSel(GRP_CLR);
    st.riseWr  = wrSel(GRP_RISE);
    st.fallWr  = wrSel(GRP_FALL);
    st.ienWr   = wrSel(GRP_IEN);
    st.statClr = wrSel(GRP_STAT);
    st.edgeClr = wrSel(GRP_EDGE);
    st.data    = wrData;
    st.rdEn    = rdEn;
    st.rdHit   = hit;
    st.rdGrp   = grp_e'(grp);
    st.rdBank  = hit ? BIDX_W'(BANKS - 1 - int'(slot)) : '0;
  end

  // a single write reaches at most one register bank
  assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.dirWr, st.setWr, st.clrWr, st.riseWr, st.fallWr,
              st.ienWr, st.statClr, st.edgeClr}));
endmodule

// File: rtl/gpx_datapath.sv
module gpx_datapath
  import gpx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic [LINES-1:0]  pinIn,
  output logic [LINES-1:0]  pinOut,
  output logic [LINES-1:0]  pinOe,
  output logic              irqOut,
  output logic [BANK_W-1:0] rdData
);
  logic [LINES-1:0] dirR, outR, riseR, fallR, ienR, statR, edgeR;
  logic [LINES-1:0] syncA, syncB, prevR;
  logic [LINES-1:0] dirNx, riseNx, fallNx, ienNx;
  logic [LINES-1:0] setMask, clrMask, statClrMask, edgeClrMask;
  logic [LINES-1:0] det;
  logic             irqR;
  logic [BANK_W-1:0] rdVal;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    localparam int LO = b * BANK_W;
    assign dirNx[LO +: BANK_W]       = st.dirWr[b]  ? st.data : dirR[LO +: BANK_W];
    assign riseNx[LO +: BANK_W]      = st.riseWr[b] ? st.data : riseR[LO +: BANK_W];
    assign fallNx[LO +: BANK_W]      = st.fallWr[b] ? st.data : fallR[LO +: BANK_W];
    assign ienNx[LO +: BANK_W]       = st.ienWr[b]  ? st.data : ienR[LO +: BANK_W];
    assign setMask[LO +: BANK_W]     = st.setWr[b]   ? st.data : '0;
    assign clrMask[LO +: BANK_W]     = st.clrWr[b]   ? st.data : '0;
    assign statClrMask[LO +: BANK_W] = st.statClr[b] ? st.data : '0;
    assign edgeClrMask[LO +: BANK_W] = st.edgeClr[b] ? st.data : '0;
  end

  assign det = (syncB & ~prevR & riseR) | (~syncB & prevR & fallR);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirR  <= '0; outR  <= '0; riseR <= '0; fallR <= '0; ienR <= '0;
      statR <= '0; edgeR <= '0; syncA <= '0; syncB <= '0; prevR <= '0;
      irqR  <= 1'b0;
    end else begin
      dirR  <= dirNx;
      riseR <= riseNx;
      fallR <= fallNx;
      ienR  <= ienNx;
      outR  <= (outR | setMask) & ~clrMask;
      syncA <= pinIn;
      syncB <= syncA;
      prevR <= syncB;
      statR <= (statR & ~statClrMask) | det;
      edgeR <= (edgeR & ~edgeClrMask) | det;
      irqR  <= |(statR & ienR);
    end
  end

  always_comb begin
    unique case (st.rdGrp)
      GRP_PIN:           rdVal = syncB[int'(st.rdBank)*BANK_W +: BANK_W];
      GRP_DIR:           rdVal = dirR[int'(st.rdBank)*BANK_W +: BANK_W];
      GRP_SET, GRP_CLR:  rdVal = outR[int'(st.rdBank)*BANK_W +: BANK_W];
      GRP_RISE:          rdVal = riseR[int'(st.rdBank)*BANK_W +: BANK_W];
      GRP_FALL:          rdVal = fallR[int'(st.rdBank)*BANK_W +: BANK_W];
      GRP_IEN:           rdVal = ienR[int'(st.rdBank)*BANK_W +: BANK_W];
      GRP_STAT:          rdVal = statR[int'(st.rdBank)*BANK_W +: BANK_W];
      GRP_EDGE:          rdVal = edgeR[int'(st.rdBank)*BANK_W +: BANK_W];
      default:           rdVal = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)          rdData <= '0;
    else if (st.rdEn)   rdData <= st.rdHit ? rdVal : '0;
  end

  assign pinOe  = dirR;
  assign pinOut = outR & dirR;
  assign irqOut = irqR;

  // a status bit may only appear on a line whose edge enables were set
  assert_edge_needs_enable_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((statR & ~$past(statR)) & ~$past(riseR | fallR)) == '0);
  // a newly raised status bit is always accompanied by its edge flag
  assert_stat_with_edge_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((statR & ~$past(statR)) & ~edgeR) == '0);
  // flags not targeted by a clear survive the cycle
  assert_stat_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(statR & ~statClrMask) & ~statR) == '0);
  assert_edge_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(edgeR & ~edgeClrMask) & ~edgeR) == '0);
  assert_irq_rise_R9: assert property (@(posedge clk) disable iff (!rstN)
    (|(statR & ienR)) |=> irqOut);
  assert_irq_fall_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(|(statR & ienR)) |=> !irqOut);
  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    (st.rdEn && !st.rdHit) |=> rdData == '0);
endmodule

// File: rtl/gpx_port.sv
module gpx_port
  import gpx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [BANK_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [BANK_W-1:0] rd_data,
  input  logic [LINES-1:0]  pin_in,
  output logic [LINES-1:0]  pin_out,
  output logic [LINES-1:0]  pin_oe,
  output logic              irq
);
  strobe_t strobes;

  gpx_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rst_n),
    .addr   (addr),
    .wrEn   (wr_en),
    .rdEn   (rd_en),
    .wrData (wr_data),
    .st     (strobes)
  );

  gpx_datapath u_dp (
    .clk    (clk),
    .rstN   (rst_n),
    .st     (strobes),
    .pinIn  (pin_in),
    .pinOut (pin_out),
    .pinOe  (pin_oe),
    .irqOut (irq),
    .rdData (rd_data)
  );
endmodule

// File: tb/gpx_port_test.sv
module gpx_port_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_data;
  logic [23:0] pin_in, pin_out, pin_oe, ext = '0;
  logic        irq;
  int          nChecks = 0;
  int          nFails = 0;

  always #4 clk = ~clk;   // 125 MHz

  // pads loop outputs back onto the inputs
  assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext);

  gpx_port uut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

  function automatic logic [5:0] ad(input int grp, input int bank);
    return 6'(grp * 4 + (2 - bank));
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    nFails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [23:0] latch;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state, R2 every mapped address
    check("R1 oe", pin_oe, 0);
    check("R1 out", pin_out, 0);
    check("R1 irq", irq, 0);
    for (int g = 0; g <= 8; g++)
      for (int b = 0; b < 3; b++) begin
        rd(ad(g, b), v); check("R1 reg", v, 0);
      end

    // R10 unmapped reads and writes
    wr(6'd3, 8'hFF); wr(6'd40, 8'hFF); wr(6'd63, 8'hFF);
    rd(6'd3, v);  check("R10 slot3", v, 0);
    rd(6'd7, v);  check("R10 slot3 dir", v, 0);
    rd(6'd36, v); check("R10 grp9", v, 0);
    rd(6'd63, v); check("R10 top", v, 0);
    check("R10 no effect", pin_oe, 0);

    // R3 R4 R5 R6 set/clear sweep on all banks, all outputs
    for (int b = 0; b < 3; b++) wr(ad(1, b), 8'hFF);
    check("R5 oe all", pin_oe, 24'hFFFFFF);
    latch = '0;
    for (int b = 0; b < 3; b++)
      for (int k = 0; k < 8; k++) begin
        logic [7:0] sp, cp;
        sp = 8'((k * 37 + b * 13 + 11) & 255);
        cp = 8'((k * 91 + b * 7 + 5) & 255);
        wr(ad(2, b), sp); latch[b*8 +: 8] |= sp;
        check("R3 pin_out after set", pin_out, latch);
        wr(ad(3, b), cp); latch[b*8 +: 8] &= ~cp;
        check("R4 pin_out after clear", pin_out, latch);
        rd(ad(2, b), v); check("R3 latch read", v, latch[b*8 +: 8]);
        rd(ad(3, b), v); check("R4 latch read", v, latch[b*8 +: 8]);
        idle(2);
        rd(ad(0, b), v); check("R6 monitor outputs", v, latch[b*8 +: 8]);
      end
    wr(ad(2, 1), 8'h00); wr(ad(3, 1), 8'h00);
    check("R3 R4 zero writes", pin_out, latch);

    // R5 R6 mixed direction
    ext = 24'hA5C33C;
    for (int b = 0; b < 3; b++) wr(ad(1, b), 8'h0F);
    check("R5 oe mixed", pin_oe, 24'h0F0F0F);
    check("R5 out gated", pin_out, latch & 24'h0F0F0F);
    idle(3);
    for (int b = 0; b < 3; b++) begin
      logic [7:0] e;
      e = (latch[b*8 +: 8] & 8'h0F) | (ext[b*8 +: 8] & 8'hF0);
      rd(ad(0, b), v); check("R6 monitor mixed", v, e);
      rd(ad(1, b), v); check("R5 dir read", v, 8'h0F);
    end
    check("R7 no edge without enable", irq, 0);
    for (int b = 0; b < 3; b++) wr(ad(1, b), 8'h00);
    ext = '0;
    idle(4);
    for (int b = 0; b < 3; b++) begin
      wr(ad(7, b), 8'hFF); wr(ad(8, b), 8'hFF); wr(ad(6, b), 8'hFF);
    end

    // R7 R8 R9 every line, every enable combination
    for (int n = 0; n < 24; n++)
      for (int m = 0; m < 4; m++) begin
        int b;
        logic [7:0] msk, re, fe;
        b = n / 8;
        msk = 8'(1 << (n % 8));
        re = (m & 1) ? msk : 8'h00;
        fe = (m & 2) ? msk : 8'h00;
        wr(ad(4, b), re); wr(ad(5, b), fe);
        ext[n] = 1'b1; idle(4);
        rd(ad(7, b), v); check("R7 rise status", v, re);
        rd(ad(8, b), v); check("R7 rise edge", v, re);
        check("R9 irq rise", irq, (m & 1) ? 1 : 0);
        wr(ad(7, b), 8'h00); rd(ad(7, b), v); check("R8 zero write keeps", v, re);
        wr(ad(7, b), msk); wr(ad(8, b), msk); idle(1);
        check("R9 irq cleared", irq, 0);
        ext[n] = 1'b0; idle(4);
        rd(ad(7, b), v); check("R7 fall status", v, fe);
        rd(ad(8, b), v); check("R7 fall edge", v, fe);
        check("R9 irq fall", irq, (m & 2) ? 1 : 0);
        wr(ad(7, b), msk); wr(ad(8, b), msk); idle(1);
        wr(ad(4, b), 8'h00); wr(ad(5, b), 8'h00);
      end

    // R9 masking by interrupt enable
    wr(ad(6, 0), 8'h00); wr(ad(4, 0), 8'h04);
    ext[2] = 1'b1; idle(4);
    check("R9 masked", irq, 0);
    wr(ad(6, 0), 8'h04); idle(1);
    check("R9 unmasked", irq, 1);
    wr(ad(6, 0), 8'h00); idle(1);
    check("R9 remasked", irq, 0);
    wr(ad(7, 0), 8'h04); wr(ad(8, 0), 8'h04);

    // R8 clear in the same cycle as a new edge: flag stays
    wr(ad(5, 0), 8'h04);
    @(negedge clk); ext[2] = 1'b0;
    @(negedge clk); @(negedge clk);
    addr = ad(7, 0); wr_data = 8'h04; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    rd(ad(7, 0), v); check("R8 edge beats clear", v, 8'h04);
    wr(ad(7, 0), 8'h04);
    rd(ad(7, 0), v); check("R8 cleared", v, 8'h00);

    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule